// File: doc/BRIEF.md
# Strobed Parallel Input Port with Handshake and Fill Threshold

The block accepts 16-bit words from an external peripheral and queues them in a 512-entry first-in first-out store, where the host drains them one at a time. The peripheral marks each word by pulling an active-low strobe line low. The block samples that line through a two-stage synchronizer and takes a word on each falling edge. It drives a handshake line back to the peripheral, and that line says when another word may be sent. Two handshake disciplines can be selected: a level-held interlock, and a short ready pulse of at most four clocks.

The host programs a fill threshold, a handshake enable, a two-bit discipline select and a port interrupt enable, and it supplies a global interrupt enable. It sees a fill flag, which is set while the stored word count is strictly above the threshold. It also sees an interrupt request, which is the fill flag qualified by both enables.

A controller with six states drives the handshake line. The states are OFF, READY, BUSY, FULL, PULSE and IDLEHI. The transitions are:
- OFF→FULL when the port is enabled and the store is full.
- OFF→PULSE or OFF→READY when the port is enabled and the store is not full, depending on the discipline.
- READY→BUSY on an accepted edge.
- BUSY→FULL when the store is full.
- BUSY→PULSE or BUSY→READY otherwise.
- FULL→PULSE or FULL→READY once a read frees a slot.
- PULSE→BUSY on an accepted edge.
- PULSE→IDLEHI after four clocks.
- IDLEHI→BUSY on an accepted edge.
- Any state→OFF while the port is disabled.

Top module: `hsk_in_port`

## Requirements
- R1: A falling edge of `strobe_n_i` is seen after a two-flop synchronizer. When it is accepted, `data_i` is written into the store on the third rising clock edge after the strobe falls, so `data_i` must stay steady for three clocks.
- R2: Words leave in arrival order. A one-cycle `rd_i` pulse removes the oldest word, which appears on `rd_data_o` after that clock edge. The store holds up to 512 words.
- R3: A read while the store is empty leaves `rd_data_o` at its last value and changes nothing else. A word that arrives while the store is full is discarded.
- R4: `fill_flag_o` is 1 exactly when the stored word count is strictly greater than `thresh_i`.
- R5: `irq_o` is 1 only when `fill_flag_o`, `port_ie_i` and `glob_ie_i` are all 1.
- R6: While `hs_en_i` is 0, the controller is in OFF and `hs_o` is held at 1. Strobe edges are still captured in this state.
- R7: `hs_sel_i` = 2'b01 selects the pulsed discipline. The values 2'b00, 2'b10 and 2'b11 select the interlock discipline. The select is read only when leaving OFF, BUSY or FULL.
- R8: In the interlock discipline, `hs_o` is 0 in READY. It goes to 1 for at least one cycle after an accepted edge, and it returns to 0 when the store is not full.
- R9: In the interlock discipline, when the store is full `hs_o` stays at 1 until a host read frees a slot.
- R10: Strobe edges that arrive in BUSY or FULL are ignored.
- R11: In the pulsed discipline, when no strobe arrives, `hs_o` is 0 for exactly four clocks and then 1 (IDLEHI). In IDLEHI, edges are still accepted.
- R12: In the pulsed discipline, an edge that arrives during the low pulse is captured, and it drives `hs_o` to 1 at once, cutting the pulse short.
- R13: After reset the controller is in OFF and the store is empty. In this state `hs_o`=1, `fill_flag_o`=0, `irq_o`=0 and `rd_data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low reset |
| strobe_n_i | input | 1 | Peripheral strobe, active low, asynchronous |
| data_i | input | 16 | Peripheral data word |
| rd_i | input | 1 | Host read pulse, removes one word |
| rd_data_o | output | 16 | Last word removed by the host |
| thresh_i | input | 10 | Fill threshold |
| hs_en_i | input | 1 | Handshake output enable |
| hs_sel_i | input | 2 | Discipline select (01 pulsed, others interlock) |
| port_ie_i | input | 1 | Port interrupt enable |
| glob_ie_i | input | 1 | Global interrupt enable |
| hs_o | output | 1 | Handshake line to peripheral, low means ready |
| fill_flag_o | output | 1 | Count strictly above threshold |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench fills the store to exactly 512 words. It then strobes while the store is full, both with the handshake enabled and with it disabled. A design that overflowed or wrapped would return the injected words where the empty-read hold value is expected. The threshold is probed one word below and one word above, which exposes a non-strict comparison.

The pulse width is measured once with no strobe and once with an edge placed inside the pulse. A design that ignored the cut-short rule would show four low cycles instead of two. A design that stopped accepting edges after the pulse would lose a word. Select value 2'b10 is checked to stay low indefinitely, which catches a decoder that reads only one bit.

// File: rtl/hsk_in_pkg.sv
package hsk_in_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_READY,
        ST_BUSY,
        ST_FULL,
        ST_PULSE,
        ST_IDLEHI
    } hsk_state_e;

    localparam logic [1:0] SEL_PULSED = 2'b01;
endpackage

// File: rtl/hsk_in_sync.sv
module hsk_in_sync (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic strobe_n_i,
    output logic fall_o
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= strobe_n_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign fall_o = s3_q & ~s2_q;
endmodule

// File: rtl/hsk_in_fifo.sv
module hsk_in_fifo #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 512,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              full_o
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q, rptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              empty, do_wr, do_rd;

    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_wr   = wr_i && !full_o;
    assign do_rd   = rd_i && !empty;
    assign count_o = cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk_i) begin
        if (do_wr) mem[wptr_q] <= wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            wptr_q    <= '0;
            rptr_q    <= '0;
            cnt_q     <= '0;
            rd_data_o <= '0;
        end else begin
            if (do_wr) wptr_q <= bump(wptr_q);
            if (do_rd) begin
                rptr_q    <= bump(rptr_q);
                rd_data_o <= mem[rptr_q];
            end
            unique case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/hsk_in_fsm.sv
module hsk_in_fsm
    import hsk_in_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic fall_i,
    input  logic full_i,
    input  logic en_i,
    input  logic pulsed_i,
    output logic accept_o,
    output logic hs_o
);
    localparam int unsigned PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

    hsk_state_e state_q, state_d;
    logic [PW-1:0] pcnt_q;
    hsk_state_e ready_st;

    assign ready_st = pulsed_i ? ST_PULSE : ST_READY;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    state_d = full_i ? ST_FULL : ready_st;
            ST_READY:  if (fall_i) state_d = ST_BUSY;
            ST_BUSY:   state_d = full_i ? ST_FULL : ready_st;
            ST_FULL:   if (!full_i) state_d = ready_st;
            ST_PULSE: begin
                if (fall_i)                            state_d = ST_BUSY;
                else if (pcnt_q == PW'(PULSE_LEN - 1)) state_d = ST_IDLEHI;
            end
            ST_IDLEHI: if (fall_i) state_d = ST_BUSY;
            default:   state_d = ST_OFF;
        endcase
        if (!en_i) state_d = ST_OFF;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= ST_OFF;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= (state_q == ST_PULSE) ? pcnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        hs_o     = 1'b1;
        accept_o = 1'b0;
        unique case (state_q)
            ST_OFF:    accept_o = fall_i;
            ST_READY:  begin hs_o = 1'b0; accept_o = fall_i; end
            ST_PULSE:  begin hs_o = 1'b0; accept_o = fall_i; end
            ST_IDLEHI: accept_o = fall_i;
            default:   ;
        endcase
    end
endmodule

// File: rtl/hsk_in_port.sv
module hsk_in_port
    import hsk_in_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned DEPTH     = 512,
    parameter int unsigned PULSE_LEN = 4,
    parameter int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              strobe_n_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [CNT_W-1:0]  thresh_i,
    input  logic              hs_en_i,
    input  logic [1:0]        hs_sel_i,
    input  logic              port_ie_i,
    input  logic              glob_ie_i,
    output logic              hs_o,
    output logic              fill_flag_o,
    output logic              irq_o
);
    logic             fall, accept, push, full;
    logic [CNT_W-1:0] fifo_count;

    hsk_in_sync u_sync (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .strobe_n_i (strobe_n_i),
        .fall_o     (fall)
    );

    hsk_in_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .fall_i   (fall),
        .full_i   (full),
        .en_i     (hs_en_i),
        .pulsed_i (hs_sel_i == SEL_PULSED),
        .accept_o (accept),
        .hs_o     (hs_o)
    );

    assign push = accept && !full;

    hsk_in_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .wr_i      (push),
        .wr_data_i (data_i),
        .rd_i      (rd_i),
        .rd_data_o (rd_data_o),
        .count_o   (fifo_count),
        .full_o    (full)
    );

    assign fill_flag_o = (fifo_count > thresh_i);
    assign irq_o       = fill_flag_o & port_ie_i & glob_ie_i;
endmodule

// File: rtl/hsk_in_port_chk.sv
module hsk_in_port_chk #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_n_i,
    input logic             hs_o,
    input logic             hs_en_i,
    input logic [1:0]       hs_sel_i,
    input logic             fill_flag_o,
    input logic             irq_o,
    input logic             port_ie_i,
    input logic             glob_ie_i,
    input logic [CNT_W-1:0] count,
    input logic             push,
    input logic             rd_i
);
    logic [2:0] lowrun_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)               lowrun_q <= '0;
        else if (hs_o)              lowrun_q <= '0;
        else if (lowrun_q != 3'd7)  lowrun_q <= lowrun_q + 1'b1;
    end

    p_pulse_len_r11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (hs_en_i && hs_sel_i == 2'b01 && lowrun_q >= 3'd4) |-> hs_o);

    p_full_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (count == CNT_W'(DEPTH)) |-> hs_o);

    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(push && count == CNT_W'(DEPTH)));

    p_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        count <= CNT_W'(DEPTH));

    p_irq_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        irq_o |-> (port_ie_i && glob_ie_i && fill_flag_o));

    p_off_high_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !hs_en_i |=> hs_o);

    p_empty_read_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rd_i && count == '0 && !push) |=> count == '0);

    p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (push && !rd_i) |=> count == CNT_W'($past(count) + 1'b1));
endmodule

bind hsk_in_port hsk_in_port_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .hs_o        (hs_o),
    .hs_en_i     (hs_en_i),
    .hs_sel_i    (hs_sel_i),
    .fill_flag_o (fill_flag_o),
    .irq_o       (irq_o),
    .port_ie_i   (port_ie_i),
    .glob_ie_i   (glob_ie_i),
    .count       (fifo_count),
    .push        (push),
    .rd_i        (rd_i)
);

// File: tb/hsk_in_port_bench.sv
module hsk_in_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_n = 1'b1;
    logic [15:0] din = '0;
    logic        rd = 1'b0;
    logic [15:0] rdata;
    logic [9:0]  thresh = '0;
    logic        hs_en = 1'b0;
    logic [1:0]  hs_sel = 2'b00;
    logic        port_ie = 1'b0;
    logic        glob_ie = 1'b0;
    logic        hs, flag, irq;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    hsk_in_port u_hsk_in_port (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .strobe_n_i  (strobe_n),
        .data_i      (din),
        .rd_i        (rd),
        .rd_data_o   (rdata),
        .thresh_i    (thresh),
        .hs_en_i     (hs_en),
        .hs_sel_i    (hs_sel),
        .port_ie_i   (port_ie),
        .glob_ie_i   (glob_ie),
        .hs_o        (hs),
        .fill_flag_o (flag),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [15:0] d, output logic saw_hi);
        saw_hi = 1'b0;
        @(negedge clk);
        din = d;
        strobe_n = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (hs) saw_hi = 1'b1;
        end
        strobe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_word(output logic [15:0] v);
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R13 hs", hs, 1);
        chk("R13 flag", flag, 0);
        chk("R13 irq", irq, 0);
        chk("R13 rdata", rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R13 hs after release", hs, 1);
    endtask

    task automatic t_off_capture;
        logic hi;
        logic [15:0] v;
        thresh = 10'd0;
        strobe(16'h1111, hi);
        chk("R6 hs parked high", hs, 1);
        chk("R4 count 1 over thresh 0", flag, 1);
        rd_word(v);
        chk("R1 captured while disabled", v, 16'h1111);
        chk("R4 flag clears", flag, 0);
    endtask

    task automatic t_thresh_irq;
        logic hi;
        logic [15:0] v;
        @(negedge clk);
        hs_sel = 2'b00;
        hs_en = 1'b1;
        thresh = 10'd2;
        repeat (2) @(negedge clk);
        chk("R8 ready low", hs, 0);
        strobe(16'hA001, hi);
        chk("R8 high after edge", hi, 1);
        chk("R8 back low", hs, 0);
        strobe(16'hA002, hi);
        chk("R4 count 2 not above 2", flag, 0);
        strobe(16'hA003, hi);
        chk("R4 count 3 above 2", flag, 1);
        @(negedge clk); port_ie = 1'b1; glob_ie = 1'b0; #1;
        chk("R5 global off", irq, 0);
        @(negedge clk); port_ie = 1'b0; glob_ie = 1'b1; #1;
        chk("R5 port off", irq, 0);
        @(negedge clk); port_ie = 1'b1; glob_ie = 1'b1; #1;
        chk("R5 both on", irq, 1);
        rd_word(v);
        chk("R2 order first", v, 16'hA001);
        chk("R5 irq drops with flag", irq, 0);
        rd_word(v);
        chk("R2 order second", v, 16'hA002);
        rd_word(v);
        chk("R2 order third", v, 16'hA003);
        port_ie = 1'b0;
        glob_ie = 1'b0;
    endtask

    task automatic t_full;
        logic hi;
        logic [15:0] v;
        int errs;
        thresh = 10'd511;
        for (int i = 0; i < 512; i++) begin
            strobe(16'(i), hi);
            if (i == 510) chk("R4 511 words not above 511", flag, 0);
        end
        chk("R4 512 words above 511", flag, 1);
        chk("R9 full holds high", hs, 1);
        repeat (10) @(negedge clk);
        chk("R9 still high", hs, 1);
        strobe(16'hDEAD, hi);
        chk("R10 edge in FULL ignored hs", hs, 1);
        @(negedge clk); hs_en = 1'b0;
        strobe(16'hBEEF, hi);
        @(negedge clk); hs_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 re-enabled while full", hs, 1);
        rd_word(v);
        chk("R2 oldest word", v, 16'h0000);
        repeat (3) @(negedge clk);
        chk("R9 released after read", hs, 0);
        errs = 0;
        for (int i = 1; i < 512; i++) begin
            rd_word(v);
            if (v !== 16'(i)) errs++;
        end
        chk("R2 drain order", errs, 0);
        rd_word(v);
        chk("R3 R10 empty read holds, no injected word", v, 16'd511);
        chk("R4 flag empty", flag, 0);
    endtask

    task automatic t_pulsed;
        logic hi;
        logic [15:0] v;
        int low;
        @(negedge clk); hs_en = 1'b0; hs_sel = 2'b01;
        repeat (2) @(negedge clk);
        hs_en = 1'b1;
        low = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (hs) break;
            low++;
        end
        chk("R11 pulse width", low, 4);
        repeat (5) @(negedge clk);
        chk("R11 idle high", hs, 1);
        strobe(16'h2222, hi);
        // Word accepted after the pulse: edge inside IDLEHI (R11)
        @(negedge clk);
        din = 16'h3333; strobe_n = 1'b0;
        @(negedge clk);
        @(negedge clk); strobe_n = 1'b1;
        @(negedge clk); din = 16'h4444; strobe_n = 1'b0;
        low = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (!hs) low++;
            else if (low != 0) break;
        end
        chk("R12 pulse cut short", low, 2);
        strobe_n = 1'b1;
        repeat (10) @(negedge clk);
        rd_word(v);
        chk("R11 idle edge captured", v, 16'h2222);
        rd_word(v);
        chk("R11 second idle edge captured", v, 16'h3333);
        rd_word(v);
        chk("R12 edge during pulse captured", v, 16'h4444);
    endtask

    task automatic t_sel_unused;
        logic hi;
        logic [15:0] v;
        int high;
        @(negedge clk); hs_en = 1'b0; hs_sel = 2'b10;
        repeat (2) @(negedge clk);
        hs_en = 1'b1;
        @(negedge clk);
        high = 0;
        repeat (12) begin
            @(negedge clk);
            if (hs) high++;
        end
        chk("R7 sel 10 acts as interlock", high, 0);
        strobe(16'h5555, hi);
        chk("R7 R8 interlock edge high", hi, 1);
        chk("R7 back low", hs, 0);
        rd_word(v);
        chk("R7 word", v, 16'h5555);
    endtask

    task automatic t_empty_read;
        logic [15:0] v;
        rd_word(v);
        chk("R3 empty read hold", v, 16'h5555);
        chk("R3 flag unchanged", flag, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_off_capture();
        t_thresh_irq();
        t_full();
        t_pulsed();
        t_sel_unused();
        t_empty_read();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule